// File: doc/BRIEF.md
# Free-Running Timer with Overflow Flag

This block is a 16-bit up-counter that runs on its own and is visible to software through a byte-wide register bus. The count shows up at two register pairs. The primary pair takes part in clearing the overflow flag. The secondary pair shows the same count and never touches the flag. Software can therefore sample the time without risk of losing an overflow event.

The counter advances only on cycles where the `tick` input is high. An external prescaler can therefore set the count rate. When the count wraps from all ones to zero, an overflow flag is set. The flag drives an interrupt request when the interrupt enable bit is set. The flag is cleared by a two-step handshake: first read status while the flag is set, then read the primary low byte. A read of either high byte captures the matching low byte. The next low-byte read of that pair then returns a coherent 16-bit sample.

Top module: `ovf_timer`

## Requirements
- R1: After a synchronous active-low reset, the count is 0xFFFC. The overflow flag and the interrupt enable read 0, and `irq` is low.
- R2: The count rises by one on each cycle where `tick` is high, wraps from 0xFFFF to 0x0000, and holds on cycles where `tick` is low.
- R3: The overflow flag (status register 0x13, bit 7) is set on the tick cycle where the count wraps from 0xFFFF to 0x0000. The first overflow after reset therefore comes on the fourth tick.
- R4: A status read (address 0x13) that sees the flag set arms the clear. A later read of the primary low byte (0x21) then clears the flag and the arm.
- R5: A read of 0x21 when no clear is armed leaves the flag set.
- R6: If a wrap occurs while the clear is armed, the flag stays set and the arm is cancelled. A following 0x21 read then leaves the flag set.
- R7: Reads of the secondary pair (0x22 high, 0x23 low) never clear the flag and never cancel an armed clear.
- R8: Register reads never alter the count. Bus writes to 0x13 and to 0x20 to 0x23 have no effect.
- R9: Reading a high byte (0x20 or 0x22) captures that cycle's low count byte for its own pair only. The next low-byte read of that pair returns the captured byte. A low-byte read with no pending capture returns the live low byte.
- R10: Control register 0x12 holds the interrupt enable in bit 7. This bit can be written and read back, and the other bits read 0. `irq` equals the flag AND the enable.
- R11: Read data is combinational during the `rd` cycle. 0x20 and 0x22 return count bits 15:8. Unmapped addresses return 0, and `rdata` is 0 when `rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Count enable, one cycle per count step |
| addr | input | 8 | Register byte address |
| rd | input | 1 | Read strobe, side effects at the clock edge |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd is high |
| irq | output | 1 | Overflow interrupt request |

## Verification
A wrong internal state shows up quickly at the ports. If the count is wrong, the next high-byte or live low-byte read returns a mismatched byte. If the flag or arm state is wrong, the next status read shows the wrong bit 7, or `irq` differs from the expected value in the same cycle. A lost or stale capture shows as a mismatched low byte on the first low read after a high read. Because the bench checks every cycle against its model, a fault appears within one bus access of its cause. The exception is a wrap-related fault, which appears once the wrap has happened.

// File: rtl/ovft_pkg.sv
// Shared constants for the free-running timer: widths, reset value,
// register byte addresses and bit positions.
package ovft_pkg;
    localparam int              CNT_W     = 16;
    localparam int              BYTE_W    = 8;
    localparam int              N_PAIRS   = 2;
    localparam logic [CNT_W-1:0] CNT_RESET = 16'hFFFC;
    localparam logic [7:0]      A_CTL     = 8'h12;
    localparam logic [7:0]      A_STS     = 8'h13;
    localparam logic [7:0]      A_PAIR0   = 8'h20;
    localparam int              IEN_BIT   = 7;
    localparam int              FLAG_BIT  = 7;
endpackage

// File: rtl/ovft_counter.sv
// Free-running up-counter with a count-enable tick.
// Assumes: tick is synchronous to clk; reset is synchronous, active low.
// Emits a one-cycle wrap pulse on the tick that rolls all ones to zero.
module ovft_counter #(
    parameter int              W         = 16,
    parameter logic [W-1:0]    RESET_VAL = 16'hFFFC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Wrap event: a tick while the count is at its maximum.
    assign wrap = tick && (cnt == {W{1'b1}});

    // Count register: load the reset value, then step on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= RESET_VAL;
        else if (tick)
            cnt <= cnt + ONE;
    end

    p_reset_val_r1: assert property (@(posedge clk)
        !rst_n |=> cnt == RESET_VAL);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt == $past(cnt) + ONE);
endmodule

// File: rtl/ovft_snap.sv
// Low-byte capture for one register pair.
// Assumes: hi_rd and lo_rd are never high in the same cycle.
// A high-byte read captures the live low byte. The next low-byte read
// returns the captured byte and releases it; otherwise the live byte shows.
module ovft_snap #(
    parameter int W  = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hi_rd,
    input  logic          lo_rd,
    input  logic [W-1:0]  live,
    output logic [BW-1:0] lo_out
);
    logic [BW-1:0] hold_q;
    logic          valid_q;

    // Capture register: load on a high read, release on a low read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            valid_q <= 1'b0;
        end else if (hi_rd) begin
            hold_q  <= live[BW-1:0];
            valid_q <= 1'b1;
        end else if (lo_rd) begin
            valid_q <= 1'b0;
        end
    end

    // Low-byte view: captured byte while pending, else the live count.
    assign lo_out = valid_q ? hold_q : live[BW-1:0];

    p_coherent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rd |=> lo_out == $past(live[BW-1:0]));
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd |=> lo_out == live[BW-1:0]);
endmodule

// File: rtl/ovft_flag.sv
// Overflow flag, clear-sequence arm and interrupt enable.
// Assumes: wrap is a one-cycle pulse; sts_rd and lo_rd are exclusive.
// Priority at each edge: wrap sets the flag and cancels the arm, then an
// armed low-byte read clears both, then a status read arms if flag is set.
module ovft_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic sts_rd,
    input  logic lo_rd,
    input  logic ctl_wr,
    input  logic ctl_bit,
    output logic flag,
    output logic ien,
    output logic irq
);
    logic arm_q;

    // Flag and arm state machine for the two-step clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            arm_q <= 1'b0;
        end else if (wrap) begin
            flag  <= 1'b1;
            arm_q <= 1'b0;
        end else if (lo_rd && arm_q) begin
            flag  <= 1'b0;
            arm_q <= 1'b0;
        end else if (sts_rd && flag) begin
            arm_q <= 1'b1;
        end
    end

    // Interrupt enable register, written through the control address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien <= 1'b0;
        else if (ctl_wr)
            ien <= ctl_bit;
    end

    // Interrupt request from the flag gated by the enable.
    assign irq = flag & ien;

    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag);
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q && lo_rd && !wrap |=> !flag);
    p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !arm_q |=> flag);
    p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q && wrap |=> flag && !arm_q);
    p_arm_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q |-> flag);
endmodule

// File: rtl/ovf_timer.sv
// Top of the free-running timer: address decode, read mux, and the two
// register pairs built by a generate loop over N_PAIRS.
// Assumes: rd and wr are not both high; the bus is synchronous to clk.
// Pair 0 is the primary pair whose low read takes part in clearing the
// flag; pair 1 is the secondary, side-effect-free view.
module ovf_timer
    import ovft_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [7:0] addr,
    input  logic       rd,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq
);
    logic [CNT_W-1:0]  cnt;
    logic              wrap;
    logic              flag;
    logic              ien;
    logic [N_PAIRS-1:0] hi_rd;
    logic [N_PAIRS-1:0] lo_rd;
    logic [BYTE_W-1:0] lo_b [N_PAIRS];
    logic              sts_rd;
    logic              ctl_rd;
    logic              ctl_wr;
    logic              unused_wbits;

    // Strobe decode for the control and status registers.
    assign sts_rd = rd && (addr == A_STS);
    assign ctl_rd = rd && (addr == A_CTL);
    assign ctl_wr = wr && !rd && (addr == A_CTL);
    assign unused_wbits = ^{wdata[IEN_BIT-1:0]};

    ovft_counter #(.W(CNT_W), .RESET_VAL(CNT_RESET)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .cnt  (cnt),
        .wrap (wrap)
    );

    // One capture stage per register pair at consecutive byte addresses.
    for (genvar g = 0; g < N_PAIRS; g++) begin : g_pair
        localparam logic [7:0] HI_A = A_PAIR0 + 8'(2 * g);
        localparam logic [7:0] LO_A = HI_A + 8'd1;

        assign hi_rd[g] = rd && (addr == HI_A);
        assign lo_rd[g] = rd && (addr == LO_A);

        ovft_snap #(.W(CNT_W), .BW(BYTE_W)) u_snap (
            .clk   (clk),
            .rst_n (rst_n),
            .hi_rd (hi_rd[g]),
            .lo_rd (lo_rd[g]),
            .live  (cnt),
            .lo_out(lo_b[g])
        );
    end

    ovft_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (wrap),
        .sts_rd (sts_rd),
        .lo_rd  (lo_rd[0]),
        .ctl_wr (ctl_wr),
        .ctl_bit(wdata[IEN_BIT]),
        .flag   (flag),
        .ien    (ien),
        .irq    (irq)
    );

    // Read mux: zero unless a mapped register is addressed during rd.
    always_comb begin
        rdata = '0;
        if (ctl_rd)
            rdata[IEN_BIT] = ien;
        else if (sts_rd)
            rdata[FLAG_BIT] = flag;
        for (int p = 0; p < N_PAIRS; p++) begin
            if (hi_rd[p])
                rdata = cnt[CNT_W-1:BYTE_W];
            else if (lo_rd[p])
                rdata = lo_b[p];
        end
    end

    p_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !rd && !tick |=> $stable(cnt));
    p_read_keeps_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !tick |=> $stable(cnt));
    p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> rdata == 8'h00);
endmodule

// File: tb/sim_ovf_timer.sv
`timescale 1ns/1ps
module sim_ovf_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] m_cnt;
    logic        m_flag, m_arm, m_ien;
    logic        m_hv [2];
    logic [7:0]  m_hold [2];

    always #4 clk = ~clk;

    ovf_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .rd(rd),
        .wr(wr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h12: return {m_ien, 7'b0};
            8'h13: return {m_flag, 7'b0};
            8'h20, 8'h22: return m_cnt[15:8];
            8'h21: return m_hv[0] ? m_hold[0] : m_cnt[7:0];
            8'h23: return m_hv[1] ? m_hold[1] : m_cnt[7:0];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h12: return "R10";
            8'h13: return "R4";
            8'h20, 8'h21: return "R9";
            8'h22, 8'h23: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cnt = 16'hFFFC; m_flag = 0; m_arm = 0; m_ien = 0;
        for (int p = 0; p < 2; p++) begin m_hv[p] = 0; m_hold[p] = 8'h00; end
    endtask

    // Model one clock edge from the requirements.
    task automatic model_step(input logic [7:0] a, input logic r, input logic w,
                              input logic [7:0] d, input logic t);
        logic wr_ev;
        wr_ev = t && (m_cnt == 16'hFFFF);
        if (wr_ev) begin m_flag = 1; m_arm = 0; end
        else if (r && a == 8'h21 && m_arm) begin m_flag = 0; m_arm = 0; end
        else if (r && a == 8'h13 && m_flag) m_arm = 1;
        for (int p = 0; p < 2; p++) begin
            if (r && a == 8'(8'h20 + 2 * p)) begin m_hv[p] = 1; m_hold[p] = m_cnt[7:0]; end
            else if (r && a == 8'(8'h21 + 2 * p)) m_hv[p] = 0;
        end
        if (w && !r && a == 8'h12) m_ien = d[7];
        if (t) m_cnt = m_cnt + 16'd1;
    endtask

    // One bus cycle: drive after the falling edge, check, then step the model.
    task automatic op(input logic [7:0] a, input logic r, input logic w,
                      input logic [7:0] d, input logic t, input string req);
        @(negedge clk);
        addr = a; rd = r; wr = w; wdata = d; tick = t;
        #1;
        chk(req, rdata, r ? exp_rd(a) : 8'h00);
        chk("R10", {7'b0, irq}, {7'b0, m_flag & m_ien});
        @(posedge clk);
        model_step(a, r, w, d, t);
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) op(8'h00, 1'b0, 1'b0, 8'h00, 1'b1, "R2");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state at the ports
        addr = 8'h20; rd = 1'b1; #1;
        chk("R1", rdata, 8'hFF);
        addr = 8'h13; #1;
        chk("R1", rdata, 8'h00);
        chk("R1", {7'b0, irq}, 8'h00);
        rd = 1'b0;
        op(8'h12, 1, 0, 0, 0, "R1");
        op(8'h21, 1, 0, 0, 0, "R1");
        // R8: writes to counter and status ignored, count unchanged
        op(8'h20, 0, 1, 8'h12, 0, "R8");
        op(8'h21, 0, 1, 8'h34, 0, "R8");
        op(8'h13, 0, 1, 8'h00, 0, "R8");
        op(8'h22, 1, 0, 0, 0, "R8");
        op(8'h23, 1, 0, 0, 0, "R8");
        chk("R8", m_cnt[7:0], 8'hFC);
        op(8'h55, 1, 0, 0, 0, "R11");
        // R9: capture across count steps and pair independence
        op(8'h20, 1, 0, 0, 1, "R9");
        op(8'h00, 0, 0, 0, 1, "R2");
        op(8'h22, 1, 0, 0, 0, "R9");
        op(8'h23, 1, 0, 0, 0, "R9");
        op(8'h21, 1, 0, 0, 0, "R9");
        op(8'h21, 1, 0, 0, 0, "R9");
        // R3: wrap on the fourth tick after reset
        run_ticks(2);
        op(8'h13, 1, 0, 0, 0, "R3");
        chk("R3", {m_flag, 7'b0}, 8'h80);
        // R10: enable drives irq; other control bits read zero
        op(8'h12, 0, 1, 8'hFF, 0, "R10");
        op(8'h12, 1, 0, 0, 0, "R10");
        // R7: secondary reads between arm and clear keep the arm
        op(8'h22, 1, 0, 0, 0, "R7");
        op(8'h23, 1, 0, 0, 0, "R7");
        op(8'h21, 1, 0, 0, 0, "R7");
        op(8'h13, 1, 0, 0, 0, "R4");
        chk("R4", {m_flag, 7'b0}, 8'h00);
        // R5: low read without arm keeps the flag
        run_ticks(65536);
        op(8'h21, 1, 0, 0, 0, "R5");
        op(8'h13, 1, 0, 0, 0, "R5");
        // R6: wrap after arming cancels the arm
        run_ticks(65536);
        op(8'h21, 1, 0, 0, 0, "R6");
        op(8'h13, 1, 0, 0, 0, "R6");
        chk("R6", {m_flag, 7'b0}, 8'h80);
        op(8'h12, 0, 1, 8'h00, 0, "R10");
        // Random phase against the model
        for (int i = 0; i < 30000; i++) begin
            logic [7:0] a;
            logic r, w, t;
            int sel;
            sel = int'($urandom_range(0, 7));
            case (sel)
                0: a = 8'h12; 1: a = 8'h13; 2: a = 8'h20; 3: a = 8'h21;
                4: a = 8'h22; 5: a = 8'h23; 6: a = 8'h21;
                default: a = 8'($urandom_range(0, 255));
            endcase
            r = ($urandom_range(0, 9) < 6);
            w = !r && ($urandom_range(0, 3) == 0);
            t = $urandom_range(0, 1) == 1;
            op(a, r, w, 8'($urandom_range(0, 255)), t, tag_of(a));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule